// File: doc/BRIEF.md
# Filtered Host Reset Stretcher

This block produces the local reset for a plug-in card. It takes an active-low reset from the host, removes short glitches from it, and turns each valid reset into a local reset of guaranteed minimum length. If the host holds its reset longer than that, the local reset lasts until the host lets go. The local reset is also forced whenever either card supply flag reports a supply below its trip point, or when the power controller asks for reset.

The local reset appears on two outputs of opposite polarity. A third, active-low output reports that the card signals are valid. It is asserted only while card power is good, no controller request is pending, and the internal stretch timer has run out. The host input is asynchronous and is brought into the clock domain through a synchronizer of `SYNC_STAGES` flops. All time values are clock-cycle parameters.

Top module: `card_reset_gen`

## Requirements
- R1: While `rst_ni` is low, `local_rst_no` is 0, `local_rst_o` is 1 and `sig_valid_no` is 1.
- R2: A low pulse on `host_rst_ni` that the synchronizer samples for fewer than `FILT_CYC` consecutive cycles leaves all outputs unchanged and restarts no timer.
- R3: A low on `host_rst_ni` that is sampled for `FILT_CYC` consecutive cycles asserts local reset (`local_rst_no` = 0).
- R4: Once it is started by the host, local reset stays asserted for at least `STRETCH_CYC` cycles, even if the host releases earlier.
- R5: If the host reset is still low when the stretch ends, local reset stays asserted until the filtered host reset goes high, and then deasserts with no further stretch.
- R6: A card supply flag (`card_lo_ok_i` or `card_hi_ok_i`) at 0 asserts local reset on the next clock edge. When both flags return to 1, a full `STRETCH_CYC` stretch follows.
- R7: `ctrl_rst_req_i` = 1 asserts local reset on the next clock edge. A full stretch follows its removal.
- R8: `local_rst_o` is always the inverse of `local_rst_no`.
- R9: `sig_valid_no` is 0 only when both supply flags are 1, no controller request is present, and the stretch timer has expired. A host reset held past the stretch does not deassert it.
- R10: After `rst_ni` is released with power good, local reset stays asserted for a full stretch period before it first deasserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_rst_ni | input | 1 | Active-low host reset (asynchronous) |
| card_lo_ok_i | input | 1 | Low-voltage card supply above trip (1 = good) |
| card_hi_ok_i | input | 1 | High-voltage card supply above trip (1 = good) |
| ctrl_rst_req_i | input | 1 | Power controller reset request (1 = force reset) |
| local_rst_no | output | 1 | Local reset, active low |
| local_rst_o | output | 1 | Local reset, active high |
| sig_valid_no | output | 1 | Card signals valid, active low |

## Verification
The host input receives glitches of every length below the filter width, a pulse of exactly the filter width, and a hold that lasts three stretch periods. Together these separate the filter threshold, the minimum stretch, and the extension that follows the host hold. Supply flags and the controller request are dropped while the stretch is idle and also while it is running. This shows that the timer restarts on their removal and is not merely extended. Signal-valid is compared during a long host hold, which separates its timer-only dependence from the local reset.

// File: rtl/card_rst_pkg.sv
package card_rst_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HOST = 2'd1,
    SRC_PWR  = 2'd2
  } rst_src_e;
endpackage

// File: rtl/host_rst_filter.sv
module host_rst_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rst_ni,
  output logic filt_lo_o,
  output logic start_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] FMAX = CW'(FILT_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0] lo_cnt_q;
  logic filt_q, start_q, filt_d;
  logic host_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= host_rst_ni;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], host_rst_ni};
    end
  endgenerate

  assign host_s = sync_q[SYNC_STAGES-1];
  assign filt_d = !host_s && (lo_cnt_q >= FMAX - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      filt_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      if (host_s)              lo_cnt_q <= '0;
      else if (lo_cnt_q != FMAX) lo_cnt_q <= lo_cnt_q + 1'b1;
      filt_q  <= filt_d;
      start_q <= filt_d & ~filt_q;
    end
  end

  assign filt_lo_o = filt_q;
  assign start_o   = start_q;

  // R3
  filt_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_q |-> $past(!host_s));
  // R2
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
endmodule

// File: rtl/rst_stretch_timer.sv
module rst_stretch_timer #(
  parameter int STRETCH_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic host_hold_i,
  input  logic pwr_hold_i,
  output logic expired_o,
  output card_rst_pkg::rst_src_e src_o
);
  import card_rst_pkg::*;
  localparam int TW = $clog2(STRETCH_CYC + 1);
  localparam logic [TW-1:0] TLOAD = TW'(STRETCH_CYC);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= TLOAD;
    else if (pwr_hold_i)     cnt_q <= TLOAD;
    else if (start_i)        cnt_q <= TLOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  always_comb begin
    if (pwr_hold_i)                     src_o = SRC_PWR;
    else if (host_hold_i || !expired_o) src_o = SRC_HOST;
    else                                src_o = SRC_NONE;
  end

  // R6
  pwr_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_hold_i |=> !expired_o);
endmodule

// File: rtl/card_reset_gen.sv
module card_reset_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2,
  parameter int STRETCH_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rst_ni,
  input  logic card_lo_ok_i,
  input  logic card_hi_ok_i,
  input  logic ctrl_rst_req_i,
  output logic local_rst_no,
  output logic local_rst_o,
  output logic sig_valid_no
);
  import card_rst_pkg::*;

  logic filt_lo, start, expired, pwr_hold, card_ok;
  rst_src_e src;
  logic rst_n_q, rst_q, sv_n_q;

  assign card_ok  = card_lo_ok_i & card_hi_ok_i;
  assign pwr_hold = ~card_ok | ctrl_rst_req_i;

  host_rst_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_rst_ni(host_rst_ni),
    .filt_lo_o(filt_lo), .start_o(start)
  );

  rst_stretch_timer #(.STRETCH_CYC(STRETCH_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .host_hold_i(filt_lo),
    .pwr_hold_i(pwr_hold), .expired_o(expired), .src_o(src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
      sv_n_q  <= 1'b1;
    end else begin
      rst_n_q <= (src == SRC_NONE);
      rst_q   <= (src != SRC_NONE);
      sv_n_q  <= ~(card_ok & ~ctrl_rst_req_i & expired);
    end
  end

  assign local_rst_no = rst_n_q;
  assign local_rst_o  = rst_q;
  assign sig_valid_no = sv_n_q;

  // R8
  pol_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_rst_o != local_rst_no);
  // R7
  req_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_req_i |=> !local_rst_no);
  // R9
  valid_needs_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_valid_no |-> $past(card_ok && !ctrl_rst_req_i));
  // R4
  timer_holds_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expired |=> !local_rst_no);
endmodule

// File: tb/sim_card_reset_gen.sv
module sim_card_reset_gen;
  localparam int SY = 2, F = 4, S = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_n = 1'b1, lo_ok = 1'b1, hi_ok = 1'b1, req = 1'b0;
  logic lrst_n, lrst, sv_n;
  int total = 0, bad = 0, cyc = 0;
  string cur = "R1";

  always #10 clk = ~clk;

  card_reset_gen #(.SYNC_STAGES(SY), .FILT_CYC(F), .STRETCH_CYC(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_rst_ni(host_n), .card_lo_ok_i(lo_ok),
    .card_hi_ok_i(hi_ok), .ctrl_rst_req_i(req), .local_rst_no(lrst_n),
    .local_rst_o(lrst), .sig_valid_no(sv_n)
  );

  // behavioural reference model
  logic sq[$];
  int lo_run, cnt;
  logic filt, strt, e_rst_n, e_sv_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = {};
      for (int i = 0; i < SY; i++) sq.push_back(1'b1);
      lo_run = 0; filt = 0; strt = 0; cnt = S; e_rst_n = 0; e_sv_n = 1;
    end else begin
      logic hs, ph, fn, okp;
      int cn;
      hs = sq[SY-1];
      ok_p: okp = lo_ok && hi_ok;
      ph = !okp || req;
      lo_run = hs ? 0 : lo_run + 1;
      fn = (lo_run >= F);
      cn = ph ? S : (strt ? S : (cnt > 0 ? cnt - 1 : 0));
      e_rst_n = !(ph || filt || cnt != 0);
      e_sv_n  = !(okp && !req && cnt == 0);
      strt = fn && !filt;
      filt = fn;
      cnt = cn;
      void'(sq.pop_back());
      sq.push_front(host_n);
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk(cur, "local_rst_no", lrst_n, e_rst_n);
    chk(cur, "sig_valid_no", sv_n, e_sv_n);
    chk("R8", "local_rst_o", lrst, ~lrst_n);
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_low(int n);
    host_n = 1'b0; wait_cyc(n); host_n = 1'b1;
  endtask

  initial begin
    int len;
    wait_cyc(5);
    // R1: reset values
    chk("R1", "local_rst_no", lrst_n, 1'b0);
    chk("R1", "local_rst_o", lrst, 1'b1);
    chk("R1", "sig_valid_no", sv_n, 1'b1);
    rst_n = 1'b1;
    cur = "R10";
    wait_cyc(S - 2);
    chk("R10", "local_rst_no early", lrst_n, 1'b0);
    wait_cyc(10);
    chk("R10", "local_rst_no done", lrst_n, 1'b1);
    chk("R10", "sig_valid_no done", sv_n, 1'b0);
    // R2: glitches shorter than the filter
    cur = "R2";
    for (int g = 1; g < F; g++) begin
      host_low(g);
      wait_cyc(8);
      chk("R2", "local_rst_no after glitch", lrst_n, 1'b1);
      chk("R2", "sig_valid_no after glitch", sv_n, 1'b0);
    end
    // R3/R4: pulse of exactly filter width
    cur = "R3";
    host_low(F);
    wait_cyc(SY + 1);
    chk("R3", "local_rst_no asserted", lrst_n, 1'b0);
    cur = "R4";
    len = 0;
    while (!lrst_n && len < 5 * S) begin wait_cyc(1); len++; end
    chk("R4", "stretch length >= S", len + SY + 1 >= S, 1'b1);
    wait_cyc(5);
    // R5/R9: long hold
    cur = "R5";
    host_n = 1'b0;
    wait_cyc(3 * S);
    chk("R5", "held past stretch", lrst_n, 1'b0);
    chk("R9", "sig_valid during long hold", sv_n, 1'b0);
    host_n = 1'b1;
    wait_cyc(SY + 3);
    chk("R5", "released without stretch", lrst_n, 1'b1);
    wait_cyc(5);
    // R6: supply flags, idle and mid-stretch
    cur = "R6";
    lo_ok = 1'b0; wait_cyc(1);
    chk("R6", "lo flag forces reset", lrst_n, 1'b0);
    chk("R9", "lo flag drops valid", sv_n, 1'b1);
    wait_cyc(4); lo_ok = 1'b1;
    wait_cyc(S - 3);
    chk("R6", "stretch after lo flag", lrst_n, 1'b0);
    wait_cyc(S);
    host_low(F + 2);
    wait_cyc(8);
    hi_ok = 1'b0; wait_cyc(3); hi_ok = 1'b1;
    wait_cyc(S - 3);
    chk("R6", "restart after hi flag", lrst_n, 1'b0);
    wait_cyc(S);
    // R7: controller request
    cur = "R7";
    req = 1'b1; wait_cyc(1);
    chk("R7", "request forces reset", lrst_n, 1'b0);
    chk("R9", "request drops valid", sv_n, 1'b1);
    wait_cyc(2); req = 1'b0;
    wait_cyc(S - 3);
    chk("R7", "stretch after request", lrst_n, 1'b0);
    wait_cyc(S);
    chk("R7", "idle after request", lrst_n, 1'b1);
    // R9: glitch during stretch does not change valid path
    cur = "R9";
    host_low(F); host_low(1);
    wait_cyc(3 * S);
    chk("R9", "valid at end", sv_n, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule